// File: doc/BRIEF.md
# Bus Priority Broadcast with Lazy Arbiter Update

This block holds the global priority level of four bus masters (two processors, a DMA read channel and a DMA write channel) in a register that software writes over an APB-style interface. It fans the levels out to a parameterised number of downstream crossbar arbiters. Each arbiter keeps its own copy and only takes up the global value at the moment it begins servicing a new nonsequential transfer. A change in priority therefore reaches each arbiter when that arbiter reaches a transfer boundary, and not before.

Software learns that a change has fully propagated through a read-only acknowledge flag. Any write to the priority register drops the flag, including a write that repeats the current value. The flag rises again one clock after the last arbiter has resampled. The arbiters' grant logic is not part of the block. Each arbiter is represented by a single strobe that marks the start of a new nonsequential transfer, and by the four-bit local copy that the block returns to it.

Top module: `prio_bcast`

## Requirements
- R1: While rst_ni is low, the priority word reads 0, the acknowledge word reads 0 and every local copy is 0.
- R2: The priority word is at offset 0x0. Bit 0 is processor 0, bit 4 is processor 1, bit 8 is DMA read and bit 12 is DMA write, where 1 means high and 0 means low. All other bits read 0. The word is written in an APB access phase (psel_i, penable_i and pwrite_i all high).
- R3: Local copy k (arb_prio_o[4k+3:4k], holding processor 0, processor 1, DMA read and DMA write from the LSB up) changes only at a clock edge where nseq_start_i[k] is high. At that edge it takes the global priority.
- R4: An arbiter that samples in the same cycle as a priority write takes the newly written value.
- R5: Every write to offset 0x0 makes the acknowledge read 0 from the next cycle onward, even when the written value equals the old one. It stays 0 until every arbiter has sampled at or after that write.
- R6: The acknowledge is bit 0 of offset 0x4, and the other bits read 0. Once every arbiter has sampled since the last priority write, it reads 1 after one further clock edge.
- R7: Reads of any offset other than 0x0 and 0x4 return 0. Writes to those offsets, and writes to 0x4, change neither the priority nor the acknowledge.
- R8: pready_o is always 1 and pslverr_o is always 0.
- R9: Whenever the acknowledge is 1, every local copy equals the global priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | DATA_W | APB write data |
| prdata_o | output | DATA_W | APB read data |
| pready_o | output | 1 | APB ready, tied high |
| pslverr_o | output | 1 | APB error, tied low |
| nseq_start_i | input | N_ARB | Per-arbiter strobe: new nonsequential transfer starts |
| arb_prio_o | output | 4*N_ARB | Per-arbiter local priority copies |

## Verification
The hardest state to reach is the acknowledge held low by a single arbiter that has not yet sampled while all the others have already resampled. A related case is a priority write that lands in the same cycle as an arbiter's strobe. Directed sequences create both. In the first, a value is written, then nine of the ten arbiters are strobed one at a time while the acknowledge is read, and only then is the last arbiter strobed. In the second, a write is issued with every strobe raised in its access cycle. Random traffic then mixes writes, repeated writes, reads and sparse strobes, so that the acknowledge windows open and close many times.

// File: rtl/prio_bcast_pkg.sv
`timescale 1ns/1ps
package prio_bcast_pkg;
  localparam int unsigned NUM_MASTERS  = 4;
  localparam int unsigned FIELD_STRIDE = 4;
  localparam int unsigned FIELD_W      = NUM_MASTERS * FIELD_STRIDE;
  localparam int unsigned PRIO_OFS     = 'h0;
  localparam int unsigned ACK_OFS      = 'h4;

  // master index == field number; bit position = index * FIELD_STRIDE
  typedef enum int unsigned {
    M_CPU0  = 0,
    M_CPU1  = 1,
    M_DMARD = 2,
    M_DMAWR = 3
  } master_e;

  typedef logic [NUM_MASTERS-1:0] prio_vec_t;

  function automatic prio_vec_t word_to_prio(input logic [FIELD_W-1:0] w);
    prio_vec_t v;
    for (int i = 0; i < NUM_MASTERS; i++) v[i] = w[i*FIELD_STRIDE];
    return v;
  endfunction

  function automatic logic [FIELD_W-1:0] prio_to_word(input prio_vec_t v);
    logic [FIELD_W-1:0] w;
    w = '0;
    for (int i = 0; i < NUM_MASTERS; i++) w[i*FIELD_STRIDE] = v[i];
    return w;
  endfunction
endpackage

// File: rtl/prio_bcast_regs.sv
`timescale 1ns/1ps
module prio_bcast_regs
  import prio_bcast_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  input  logic              ack_i,
  output prio_vec_t         glob_o,
  output prio_vec_t         glob_nxt_o,
  output logic              wr_prio_o,
  output logic [DATA_W-1:0] prdata_o
);
  localparam logic [ADDR_W-1:0] PRIO_A = ADDR_W'(PRIO_OFS);
  localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(ACK_OFS);

  prio_vec_t glob_q;
  logic      access;
  logic      unused_wdata_hi;

  assign unused_wdata_hi = ^pwdata_i[DATA_W-1:FIELD_W];
  assign access     = psel_i & penable_i;
  assign wr_prio_o  = access & pwrite_i & (paddr_i == PRIO_A);
  assign glob_nxt_o = wr_prio_o ? word_to_prio(pwdata_i[FIELD_W-1:0]) : glob_q;
  assign glob_o     = glob_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) glob_q <= '0;
    else         glob_q <= glob_nxt_o;
  end

  always_comb begin
    prdata_o = '0;
    if (psel_i && !pwrite_i) begin
      if (paddr_i == PRIO_A)     prdata_o = DATA_W'(prio_to_word(glob_q));
      else if (paddr_i == ACK_A) prdata_o = {{(DATA_W-1){1'b0}}, ack_i};
    end
  end
endmodule

// File: rtl/prio_bcast_copy.sv
`timescale 1ns/1ps
module prio_bcast_copy
  import prio_bcast_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sample_i,
  input  logic      wr_i,
  input  prio_vec_t glob_nxt_i,
  output prio_vec_t local_o,
  output logic      fresh_o
);
  prio_vec_t loc_q;
  logic      fresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loc_q   <= '0;
      fresh_q <= 1'b1;
    end else begin
      if (sample_i) loc_q <= glob_nxt_i;
      // a write invalidates the copy unless it is sampled in the same cycle
      if (wr_i)          fresh_q <= sample_i;
      else if (sample_i) fresh_q <= 1'b1;
    end
  end

  assign local_o = loc_q;
  assign fresh_o = fresh_q;
endmodule

// File: rtl/prio_bcast_ack.sv
`timescale 1ns/1ps
module prio_bcast_ack #(
  parameter int unsigned N_ARB = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [N_ARB-1:0] fresh_i,
  output logic             ack_o
);
  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ack_q <= 1'b0;
    else if (wr_i) ack_q <= 1'b0;
    else           ack_q <= &fresh_i;
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/prio_bcast.sv
`timescale 1ns/1ps
module prio_bcast
  import prio_bcast_pkg::*;
#(
  parameter int unsigned N_ARB  = 10,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         psel_i,
  input  logic                         penable_i,
  input  logic                         pwrite_i,
  input  logic [ADDR_W-1:0]            paddr_i,
  input  logic [DATA_W-1:0]            pwdata_i,
  output logic [DATA_W-1:0]            prdata_o,
  output logic                         pready_o,
  output logic                         pslverr_o,
  input  logic [N_ARB-1:0]             nseq_start_i,
  output logic [N_ARB*NUM_MASTERS-1:0] arb_prio_o
);
  prio_vec_t        glob_q;
  prio_vec_t        glob_nxt;
  logic             wr_prio;
  logic             ack_q;
  logic [N_ARB-1:0] fresh;

  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;

  prio_bcast_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .psel_i     (psel_i),
    .penable_i  (penable_i),
    .pwrite_i   (pwrite_i),
    .paddr_i    (paddr_i),
    .pwdata_i   (pwdata_i),
    .ack_i      (ack_q),
    .glob_o     (glob_q),
    .glob_nxt_o (glob_nxt),
    .wr_prio_o  (wr_prio),
    .prdata_o   (prdata_o)
  );

  for (genvar k = 0; k < N_ARB; k++) begin : g_arb
    prio_vec_t loc;
    prio_bcast_copy u_copy (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sample_i   (nseq_start_i[k]),
      .wr_i       (wr_prio),
      .glob_nxt_i (glob_nxt),
      .local_o    (loc),
      .fresh_o    (fresh[k])
    );
    assign arb_prio_o[k*NUM_MASTERS +: NUM_MASTERS] = loc;
  end

  prio_bcast_ack #(.N_ARB(N_ARB)) u_ack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_prio),
    .fresh_i (fresh),
    .ack_o   (ack_q)
  );
endmodule

// File: rtl/prio_bcast_chk.sv
`timescale 1ns/1ps
module prio_bcast_chk
  import prio_bcast_pkg::*;
#(
  parameter int unsigned N_ARB = 10
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         wr_prio,
  input prio_vec_t                    glob_q,
  input logic                         ack_q,
  input logic                         pready_o,
  input logic                         pslverr_o,
  input logic [N_ARB-1:0]             nseq_start_i,
  input logic [N_ARB*NUM_MASTERS-1:0] arb_prio_o
);
  a_r8_ready_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pready_o && !pslverr_o);

  a_r5_write_drops_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_prio |=> !ack_q);

  for (genvar k = 0; k < N_ARB; k++) begin : g_lane
    a_r3_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !nseq_start_i[k] |=> $stable(arb_prio_o[k*NUM_MASTERS +: NUM_MASTERS]));

    a_r4_take_global: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nseq_start_i[k] |=> arb_prio_o[k*NUM_MASTERS +: NUM_MASTERS] == glob_q);

    a_r9_ack_consistent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_q |-> arb_prio_o[k*NUM_MASTERS +: NUM_MASTERS] == glob_q);
  end
endmodule

bind prio_bcast prio_bcast_chk #(.N_ARB(N_ARB)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_prio      (wr_prio),
  .glob_q       (glob_q),
  .ack_q        (ack_q),
  .pready_o     (pready_o),
  .pslverr_o    (pslverr_o),
  .nseq_start_i (nseq_start_i),
  .arb_prio_o   (arb_prio_o)
);

// File: tb/prio_bcast_bench.sv
`timescale 1ns/1ps
module prio_bcast_bench;
  localparam int N = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0]   paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          pready, pslverr;
  logic [N-1:0]  nseq = '0;
  logic [4*N-1:0] arb_prio;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model
  logic [3:0]   g_m;
  logic [3:0]   loc_m [N];
  logic [N-1:0] fresh_m;
  logic         ack_m;

  always #2.5 clk = ~clk;

  prio_bcast u_prio_bcast (
    .clk_i(clk), .rst_ni(rst_ni), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .nseq_start_i(nseq),
    .arb_prio_o(arb_prio)
  );

  function automatic logic [31:0] pack_w(input logic [3:0] v);
    return {19'd0, v[3], 3'd0, v[2], 3'd0, v[1], 3'd0, v[0]};
  endfunction

  function automatic logic [3:0] unpack_w(input logic [31:0] w);
    return {w[12], w[8], w[4], w[0]};
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    if (a == 12'h0) return pack_w(g_m);
    if (a == 12'h4) return {31'd0, ack_m};
    return 32'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic e, input logic w,
                      input logic [11:0] a, input logic [31:0] d, input logic [N-1:0] ns);
    logic wrp;
    logic [3:0] ng;
    @(negedge clk);
    psel = s; penable = e; pwrite = w; paddr = a; pwdata = d; nseq = ns;
    #1;
    check("R8 ready/err", {30'd0, pready, pslverr}, 32'd2);
    for (int k = 0; k < N; k++)
      check("R3 local copy", 32'(arb_prio[4*k +: 4]), 32'(loc_m[k]));
    if (s && e && !w) begin
      if (a == 12'h0)      check("R2 prio read", prdata, exp_read(a));
      else if (a == 12'h4) check("R6 ack read", prdata, exp_read(a));
      else                 check("R7 unmapped read", prdata, exp_read(a));
    end
    wrp = s && e && w && (a == 12'h0);
    ng  = wrp ? unpack_w(d) : g_m;
    @(posedge clk);
    ack_m = wrp ? 1'b0 : &fresh_m;
    for (int k = 0; k < N; k++) begin
      if (ns[k]) loc_m[k] = ng;
      if (wrp) fresh_m[k] = ns[k];
      else if (ns[k]) fresh_m[k] = 1'b1;
    end
    g_m = ng;
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d, input logic [N-1:0] ns);
    step(1, 0, 1, a, d, '0);
    step(1, 1, 1, a, d, ns);
  endtask

  task automatic apb_rd(input logic [11:0] a);
    step(1, 0, 0, a, 0, '0);
    step(1, 1, 0, a, 0, '0);
  endtask

  task automatic idle(input logic [N-1:0] ns);
    step(0, 0, 0, 12'h0, 0, ns);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lastv;
    void'($urandom(32'd1234));
    g_m = '0; fresh_m = '1; ack_m = 1'b0;
    for (int k = 0; k < N; k++) loc_m[k] = '0;

    // R1: state held in reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = 12'h0; #1;
    check("R1 prio in reset", prdata, 32'd0);
    paddr = 12'h4; #1;
    check("R1 ack in reset", prdata, 32'd0);
    check("R1 local copies in reset", 32'(arb_prio[31:0]), 32'd0);
    psel = 0;
    rst_ni = 1'b1;

    idle('0);
    apb_rd(12'h4);

    // R2: field positions, gap bits zero
    apb_wr(12'h0, 32'hFFFF_FFFF, '0);
    step(1, 0, 0, 12'h0, 0, '0);
    step(1, 1, 0, 12'h0, 0, '0);
    check("R2 fields only", prdata, 32'h0000_1111);
    apb_rd(12'h4);
    check("R5 ack low after write", prdata, 32'd0);

    // R6: one arbiter left behind keeps ack low
    for (int k = 0; k < N - 1; k++) idle(N'(1) << k);
    apb_rd(12'h4);
    check("R6 idle arbiter holds ack", prdata, 32'd0);
    check("R3 stale lane 9", 32'(arb_prio[4*9 +: 4]), 32'd0);
    idle(N'(1) << (N - 1));
    apb_rd(12'h4);
    check("R6 ack after last sample", prdata, 32'd1);

    // R5: rewriting same value drops ack
    apb_wr(12'h0, 32'h0000_1111, '0);
    apb_rd(12'h4);
    check("R5 same-value write drops ack", prdata, 32'd0);

    // R4: sampling in the write cycle takes the new value
    apb_wr(12'h0, 32'h0000_0001, '1);
    idle('0);
    for (int k = 0; k < N; k++)
      check("R4 new value on sample", 32'(arb_prio[4*k +: 4]), 32'h1);
    apb_rd(12'h4);
    check("R4 ack with all sampled in write cycle", prdata, 32'd1);

    // R7: unmapped and ack-offset writes ignored
    apb_wr(12'h010, 32'hFFFF_FFFF, '0);
    apb_wr(12'h004, 32'hFFFF_FFFF, '0);
    apb_rd(12'h0);
    check("R7 prio untouched", prdata, 32'h0000_0001);
    apb_rd(12'h4);
    check("R7 ack untouched", prdata, 32'd1);
    apb_rd(12'h010);
    check("R7 unmapped reads zero", prdata, 32'd0);

    // random mix
    lastv = 32'h1;
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] ns;
      int op;
      logic [11:0] a;
      for (int k = 0; k < N; k++) ns[k] = ($urandom % 8) == 0;
      op = $urandom % 10;
      case ($urandom % 6)
        0: a = 12'h4;
        1: a = 12'($urandom % 64) << 2;
        default: a = 12'h0;
      endcase
      if (op < 2) begin
        logic [31:0] d;
        d = ($urandom % 3 == 0) ? lastv : $urandom;
        lastv = d;
        apb_wr(a, d, ns);
      end else if (op < 6) begin
        step(1, 0, 0, a, 0, '0);
        step(1, 1, 0, a, 0, ns);
      end else begin
        idle(ns);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule